// File: doc/BRIEF.md
# Multi-Domain Reset Sequencer

This block turns a one-cycle system power-control command into a timed reset sequence across three reset domains: a core domain, a secondary domain and a memory domain. Each domain is driven by an active-low output. Each command bit selects a different set of domains. The sequencer holds the union of the selected domains in reset for a fixed assertion time and releases all three in the same cycle. After a second, longer delay it pulses a strobe that tells the surrounding logic to reinitialise its registers.

The same command word can also carry three other requests. The first is a power-off request, which latches a level output and takes priority over any reset bits. The second is a one-cycle sleep-notify pulse. The third is a one-cycle pulse that clears the legacy register set when a normal reboot is accepted. A legacy-mode input, sampled when the command is accepted, decides whether a normal reboot also resets the memory domain. A prescaler parameter gives the number of clocks per millisecond, so a bench can shrink both delays without changing the sequence.

Top module: `rst_sequencer`

## Requirements
- R1: After reset, coreRstN, auxRstN and memRstN are high, and powerOffReq, busy, reinitStrobe, sleepNotify and legacyClr are low.
- R2: An accepted command with bit1 set (full reboot) drives coreRstN, auxRstN and memRstN low starting in the cycle after acceptance.
- R3: An accepted command with bit2 set (normal reboot) drives auxRstN low. It drives memRstN low only if legacyMode is 1 in the accepting cycle. It also raises legacyClr for exactly one cycle, in the cycle after acceptance.
- R4: An accepted command with bit3 set drives only memRstN low.
- R5: When more than one of bits 3:1 is set, the domains driven low are the union of the sets each bit selects.
- R6: The domains stay low for exactly HOLD_MS*CLKS_PER_MS cycles, and then all three outputs return high in the same cycle.
- R7: reinitStrobe is high for exactly one cycle, REINIT_MS*CLKS_PER_MS cycles after the release. busy is high from the cycle after acceptance up to the strobe cycle, and is low in the strobe cycle.
- R8: A command presented while busy is high has no effect on any output.
- R9: An accepted command with bit0 set raises powerOffReq in the following cycle. It asserts no reset domain and does not raise busy. powerOffReq stays high, and all later commands are ignored until reset.
- R10: An accepted command with bit4 set raises sleepNotify for exactly one cycle, in the cycle after acceptance. This happens whether or not other bits are set in the same command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset of the block |
| cmdValid | input | 1 | One-cycle command strobe |
| cmd | input | 5 | Command bits: 0 power off, 1 full reboot, 2 normal reboot, 3 memory reset, 4 sleep notify |
| legacyMode | input | 1 | Normal reboot also resets the memory domain when 1 |
| coreRstN | output | 1 | Core domain reset, active low |
| auxRstN | output | 1 | Secondary domain reset, active low |
| memRstN | output | 1 | Memory domain reset, active low |
| powerOffReq | output | 1 | Latched power-off request level |
| busy | output | 1 | A reset sequence is in progress |
| reinitStrobe | output | 1 | One-cycle register-reinitialise pulse |
| sleepNotify | output | 1 | One-cycle imminent-sleep pulse |
| legacyClr | output | 1 | One-cycle legacy register set clear |

## Verification
Two functions can fire in the same cycle: the sleep-notify pulse and the start of a reset sequence, together with the legacy-clear pulse. The bench provokes this with a single command word that carries bit4 together with the normal-reboot bit. The scoreboard then expects both pulses and the falling reset outputs in the same sampled cycle. A second collision is power off combined with a full reboot and sleep. It is judged by expecting the sleep pulse and powerOffReq, with every reset output still high and busy low.

// File: rtl/rst_sequencer_pkg.sv
package rst_sequencer_pkg;

  localparam int NUM_DOMAINS = 3;
  localparam int DOM_CORE    = 0;
  localparam int DOM_AUX     = 1;
  localparam int DOM_MEM     = 2;
  localparam int CMD_W       = 5;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HOLD = 2'd1,
    SEQ_WAIT = 2'd2,
    SEQ_OFF  = 2'd3
  } seqState_t;

  // Strobes from control to datapath, valid for one cycle each
  typedef struct packed {
    logic                   startHold;
    logic                   startWait;
    logic                   releaseAll;
    logic                   fireReinit;
    logic                   fireSleep;
    logic                   firePowerOff;
    logic                   fireLegacyClr;
    logic [NUM_DOMAINS-1:0] assertMask;
  } seqStrobes_t;

  // Domains selected by the reset bits (bits 3:1 of the action field)
  function automatic logic [NUM_DOMAINS-1:0] domainsFor(input logic [3:0] act,
                                                        input logic legacy);
    logic [NUM_DOMAINS-1:0] sel;
    sel           = '0;
    sel[DOM_CORE] = act[1];
    sel[DOM_AUX]  = act[1] | act[2];
    sel[DOM_MEM]  = act[1] | act[3] | (act[2] & legacy);
    return sel;
  endfunction

endpackage

// File: rtl/rst_sequencer_ctrl.sv
module rst_sequencer_ctrl
  import rst_sequencer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmd,
  input  logic             legacyMode,
  input  logic             timerDone,
  output seqStrobes_t      strobes,
  output logic             busy
);

  seqState_t state, stateNext;
  logic      accept;
  logic      anyReset;
  logic [3:0] actField;

  // Action field: the low four bits of the command
  assign actField = cmd[3:0] & 4'hF;
  assign anyReset = |actField[3:1];
  assign accept   = cmdValid && (state == SEQ_IDLE);

  always_comb begin
    stateNext = state;
    strobes   = '0;
    unique case (state)
      SEQ_IDLE: begin
        if (accept) begin
          strobes.fireSleep = cmd[4];
          if (actField[0]) begin
            // Power off wins over every reset bit
            strobes.firePowerOff = 1'b1;
            stateNext            = SEQ_OFF;
          end else if (anyReset) begin
            strobes.startHold     = 1'b1;
            strobes.assertMask    = domainsFor(actField, legacyMode);
            strobes.fireLegacyClr = actField[2];
            stateNext             = SEQ_HOLD;
          end
        end
      end
      SEQ_HOLD: begin
        if (timerDone) begin
          strobes.releaseAll = 1'b1;
          strobes.startWait  = 1'b1;
          stateNext          = SEQ_WAIT;
        end
      end
      SEQ_WAIT: begin
        if (timerDone) begin
          strobes.fireReinit = 1'b1;
          stateNext          = SEQ_IDLE;
        end
      end
      SEQ_OFF: stateNext = SEQ_OFF;
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state == SEQ_HOLD) || (state == SEQ_WAIT);

endmodule

// File: rtl/rst_sequencer_datapath.sv
module rst_sequencer_datapath
  import rst_sequencer_pkg::*;
#(
  parameter int CLKS_PER_MS = 200000,
  parameter int HOLD_MS     = 5,
  parameter int REINIT_MS   = 100
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  seqStrobes_t            strobes,
  output logic                   timerDone,
  output logic [NUM_DOMAINS-1:0] domainOn,
  output logic                   powerOffReq,
  output logic                   reinitStrobe,
  output logic                   sleepNotify,
  output logic                   legacyClr
);

  localparam int TICK_W = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
  localparam int MS_MAX = (HOLD_MS > REINIT_MS) ? HOLD_MS : REINIT_MS;
  localparam int MS_W   = (MS_MAX > 1) ? $clog2(MS_MAX + 1) : 1;
  localparam logic [TICK_W-1:0] TICK_LAST   = TICK_W'(CLKS_PER_MS - 1);
  localparam logic [MS_W-1:0]   HOLD_LAST   = MS_W'(HOLD_MS - 1);
  localparam logic [MS_W-1:0]   REINIT_LAST = MS_W'(REINIT_MS - 1);

  logic [TICK_W-1:0] tickCnt;
  logic [MS_W-1:0]   msCnt;
  logic [MS_W-1:0]   msLast;
  logic              timerRun;
  logic              tickWrap;

  assign tickWrap  = (tickCnt == TICK_LAST);
  assign timerDone = timerRun && tickWrap && (msCnt == msLast);

  // Millisecond prescaler plus millisecond counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt  <= '0;
      msCnt    <= '0;
      msLast   <= '0;
      timerRun <= 1'b0;
    end else if (strobes.startHold || strobes.startWait) begin
      tickCnt  <= '0;
      msCnt    <= '0;
      msLast   <= strobes.startHold ? HOLD_LAST : REINIT_LAST;
      timerRun <= 1'b1;
    end else if (timerRun) begin
      if (tickWrap) begin
        tickCnt <= '0;
        if (msCnt == msLast) timerRun <= 1'b0;
        else                 msCnt    <= msCnt + 1'b1;
      end else begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

  // One hold register per reset domain
  for (genvar d = 0; d < NUM_DOMAINS; d++) begin : g_domain
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                   domainOn[d] <= 1'b0;
      else if (strobes.releaseAll) domainOn[d] <= 1'b0;
      else if (strobes.startHold)  domainOn[d] <= strobes.assertMask[d];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      powerOffReq  <= 1'b0;
      reinitStrobe <= 1'b0;
      sleepNotify  <= 1'b0;
      legacyClr    <= 1'b0;
    end else begin
      if (strobes.firePowerOff) powerOffReq <= 1'b1;
      reinitStrobe <= strobes.fireReinit;
      sleepNotify  <= strobes.fireSleep;
      legacyClr    <= strobes.fireLegacyClr;
    end
  end

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
  import rst_sequencer_pkg::*;
#(
  parameter int CLKS_PER_MS = 200000,
  parameter int HOLD_MS     = 5,
  parameter int REINIT_MS   = 100
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmd,
  input  logic             legacyMode,
  output logic             coreRstN,
  output logic             auxRstN,
  output logic             memRstN,
  output logic             powerOffReq,
  output logic             busy,
  output logic             reinitStrobe,
  output logic             sleepNotify,
  output logic             legacyClr
);

  seqStrobes_t            strobes;
  logic                   timerDone;
  logic [NUM_DOMAINS-1:0] domainOn;

  rst_sequencer_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdValid  (cmdValid),
    .cmd       (cmd),
    .legacyMode(legacyMode),
    .timerDone (timerDone),
    .strobes   (strobes),
    .busy      (busy)
  );

  rst_sequencer_datapath #(
    .CLKS_PER_MS(CLKS_PER_MS),
    .HOLD_MS    (HOLD_MS),
    .REINIT_MS  (REINIT_MS)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .timerDone   (timerDone),
    .domainOn    (domainOn),
    .powerOffReq (powerOffReq),
    .reinitStrobe(reinitStrobe),
    .sleepNotify (sleepNotify),
    .legacyClr   (legacyClr)
  );

  assign coreRstN = ~domainOn[DOM_CORE];
  assign auxRstN  = ~domainOn[DOM_AUX];
  assign memRstN  = ~domainOn[DOM_MEM];

endmodule

// File: rtl/rst_sequencer_chk.sv
module rst_sequencer_chk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic coreRstN,
  input logic auxRstN,
  input logic memRstN,
  input logic powerOffReq,
  input logic busy,
  input logic reinitStrobe,
  input logic sleepNotify,
  input logic legacyClr
);

  // R2: the core domain is only ever held together with the other two
  assert_core_implies_all_R2: assert property (@(posedge clk) disable iff (!rstN)
    !coreRstN |-> (!auxRstN && !memRstN));

  // R6: any release brings every domain out of reset at once
  assert_release_together_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(coreRstN) || $rose(auxRstN) || $rose(memRstN)) |-> (coreRstN && auxRstN && memRstN));

  // R7: strobe is a single cycle that ends a busy period
  assert_strobe_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    reinitStrobe |=> !reinitStrobe);
  assert_strobe_ends_busy_R7: assert property (@(posedge clk) disable iff (!rstN)
    reinitStrobe |-> (!busy && $past(busy)));

  // R8: a domain enters reset only from a command accepted while idle
  assert_entry_when_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(coreRstN) || $fell(auxRstN) || $fell(memRstN)) |-> ($past(cmdValid) && !$past(busy)));

  // R9: power off is sticky and keeps every domain out of reset
  assert_off_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |=> powerOffReq);
  assert_off_no_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |-> (coreRstN && auxRstN && memRstN && !busy));

  // R10: sleep notify lasts one cycle
  assert_sleep_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    sleepNotify |=> !sleepNotify);

  // R3: legacy clear lasts one cycle and comes with the secondary reset
  assert_legacy_single_R3: assert property (@(posedge clk) disable iff (!rstN)
    legacyClr |=> !legacyClr);
  assert_legacy_with_aux_R3: assert property (@(posedge clk) disable iff (!rstN)
    legacyClr |-> !auxRstN);

endmodule

bind rst_sequencer rst_sequencer_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .cmdValid    (cmdValid),
  .coreRstN    (coreRstN),
  .auxRstN     (auxRstN),
  .memRstN     (memRstN),
  .powerOffReq (powerOffReq),
  .busy        (busy),
  .reinitStrobe(reinitStrobe),
  .sleepNotify (sleepNotify),
  .legacyClr   (legacyClr)
);

// File: tb/rst_sequencer_test.sv
`timescale 1ns/1ps
module rst_sequencer_test;

  localparam int CPM    = 4;
  localparam int HOLDMS = 5;
  localparam int RINMS  = 100;
  localparam int H      = CPM * HOLDMS;
  localparam int R      = CPM * RINMS;

  logic       clk = 1'b0;
  logic       rstN;
  logic       cmdValid;
  logic [4:0] cmd;
  logic       legacyMode;
  logic coreRstN, auxRstN, memRstN, powerOffReq, busy, reinitStrobe, sleepNotify, legacyClr;

  always #2.5 clk = ~clk;

  rst_sequencer #(.CLKS_PER_MS(CPM), .HOLD_MS(HOLDMS), .REINIT_MS(RINMS)) uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmd(cmd), .legacyMode(legacyMode),
    .coreRstN(coreRstN), .auxRstN(auxRstN), .memRstN(memRstN), .powerOffReq(powerOffReq),
    .busy(busy), .reinitStrobe(reinitStrobe), .sleepNotify(sleepNotify), .legacyClr(legacyClr)
  );

  // Vector order: core, aux, mem, off, busy, strobe, sleep, legacy clear
  typedef struct {
    int         cyc;
    logic [7:0] vec;
    string      req;
  } item_t;

  item_t sb[$];
  int    cyc = 0;
  int    total = 0;
  int    bad = 0;
  bit    done = 0;

  // Reference model of the last accepted command
  int mStart = -1000000;
  int mOff   = -1;
  int mPulse = -1;
  bit mCore, mAux, mMem, mSleep, mLc;

  always @(posedge clk) if (rstN) cyc = cyc + 1;

  function automatic logic [7:0] expVec(input int t);
    bit inHold, offOn;
    inHold = (t >= mStart) && (t < mStart + H);
    offOn  = (mOff >= 0) && (t >= mOff);
    return {!(inHold && mCore), !(inHold && mAux), !(inHold && mMem), offOn,
            (t >= mStart) && (t < mStart + H + R), (t == mStart + H + R),
            (t == mPulse) && mSleep, (t == mPulse) && mLc};
  endfunction

  task automatic push(input int t, input string req);
    item_t it;
    it.cyc = t;
    it.vec = expVec(t);
    it.req = req;
    sb.push_back(it);
  endtask

  task automatic issue(input logic [4:0] c, input bit leg, input string req);
    int  a;
    bit  acc, seqStarted;
    logic [7:0] prev;
    @(negedge clk);
    cmd = c; legacyMode = leg; cmdValid = 1'b1;
    a = cyc + 1;
    prev = expVec(a - 1);
    acc = !prev[3] && !((mOff >= 0) && (a - 1 >= mOff));
    seqStarted = 0;
    if (acc) begin
      mPulse = a; mSleep = c[4]; mLc = 0;
      if (c[0]) begin
        mOff = a;
      end else if (|c[3:1]) begin
        mStart = a;
        mCore = c[1];
        mAux  = c[1] | c[2];
        mMem  = c[1] | c[3] | (c[2] & leg);
        mLc   = c[2];
        seqStarted = 1;
      end
    end
    push(a, req);
    push(a + 1, req);
    if (seqStarted) begin
      push(a + H - 1, req);
      push(a + H, "R6");
      push(a + H + R - 1, "R7");
      push(a + H + R, "R7");
      push(a + H + R + 1, "R7");
    end
    @(negedge clk);
    cmdValid = 1'b0; cmd = '0; legacyMode = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops every expected item due in the current cycle
  always @(negedge clk) begin
    logic [7:0] got;
    got = {coreRstN, auxRstN, memRstN, powerOffReq, busy, reinitStrobe, sleepNotify, legacyClr};
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        total++;
        if (got !== sb[i].vec) begin
          bad++;
          $display("FAIL %s cycle %0d: actual=%b expected=%b", sb[i].req, cyc, got, sb[i].vec);
        end
        sb.delete(i);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; cmdValid = 1'b0; cmd = '0; legacyMode = 1'b0;
    idle(4);
    rstN = 1'b1;
    @(negedge clk);
    total++;
    if ({coreRstN, auxRstN, memRstN, powerOffReq, busy, reinitStrobe, sleepNotify, legacyClr} !== 8'b1110_0000) begin
      bad++;
      $display("FAIL R1 reset state: actual=%b expected=%b",
               {coreRstN, auxRstN, memRstN, powerOffReq, busy, reinitStrobe, sleepNotify, legacyClr}, 8'b1110_0000);
    end

    issue(5'h02, 1'b0, "R2");  idle(H + R + 5);   // full reboot
    issue(5'h04, 1'b0, "R3");  idle(H + R + 5);   // normal reboot, legacy off
    issue(5'h04, 1'b1, "R3");  idle(H + R + 5);   // normal reboot, legacy on
    issue(5'h08, 1'b0, "R4");  idle(H + R + 5);   // memory only
    issue(5'h0C, 1'b0, "R5");  idle(H + R + 5);   // union aux + mem
    issue(5'h14, 1'b1, "R10"); idle(H + R + 5);   // sleep with normal reboot, same cycle
    issue(5'h08, 1'b0, "R6");  idle(5);
    issue(5'h02, 1'b0, "R8");  idle(30);          // ignored during hold
    issue(5'h16, 1'b1, "R8");  idle(H + R);       // ignored during wait
    issue(5'h10, 1'b0, "R10"); idle(5);           // sleep only
    issue(5'h13, 1'b0, "R9");  idle(3);           // off beats reboot, sleep pulses
    issue(5'h02, 1'b1, "R9");  idle(5);           // ignored after power off
    issue(5'h10, 1'b0, "R9");  idle(5);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule